// File: doc/BRIEF.md
# Compressed Instruction Field Decoder

This block turns one 16-bit compressed instruction into a uniform micro-op for the execute stage. The fetch unit gives it a 32-bit window that starts at the instruction's first halfword. If that halfword is an extension prefix, the real instruction is the second halfword, and the prefix adds the upper bits of a full 16-bit immediate. If the instruction is the 32-bit jump, the second halfword supplies the low part of the jump index.

Each micro-op carries an operation code and three register numbers. The 3-bit register fields are widened into the full 5-bit register space. The micro-op also carries a ready-to-use 32-bit immediate with its extension and scaling already applied, an immediate-select bit, the instruction length and a reserved-instruction flag. Decode is combinational and lands in a single output register that carries a valid bit.

Top module: `c16_decoder`

## Requirements
- R1: On synchronous reset, `out_valid` and every micro-op field read zero. After reset, `out_valid` equals the `in_valid` of the previous cycle, and the fields hold the decode of the window presented in that cycle.
- R2: The major opcode is bits 15:11 of the instruction, rx is bits 10:8, ry is bits 7:5 and rz is bits 4:2. A 3-bit register code 0..7 names register 16, 17, 2, 3, 4, 5, 6, 7. Register 24 is the test register and register 31 is the link register.
- R3: A first halfword with major opcode 30 is a prefix. The instruction is then `in_window[31:16]`, `out_len4` is 1, and the raw immediate is {prefix[4:0], prefix[10:5], instruction[4:0]} taken as a 16-bit value.
- R4: Major 6 is a shift with rd=rx, rs=ry. Function bits 1:0 select 0 shift-left, 2 logical-right, 3 arithmetic-right, and 1 is reserved. The unextended amount is bits 4:2, where 0 means 8. The extended amount is prefix bits 10:6.
- R5: Majors 16/17/19 load a byte/halfword/word with rd=ry, rs=rx. Majors 24/25/27 store a byte/halfword/word with rs=rx, rt=ry. The unextended offset is bits 4:0 zero-extended and multiplied by the access size. The extended offset is the sign-extended raw immediate, unscaled.
- R6: Major 2 branches always, using bits 10:0 sign-extended and doubled. Majors 4 and 5 branch if rs=rx is zero or non-zero, using bits 7:0 sign-extended and doubled. Major 12 with function bits 10:8 equal to 0 or 1 does the same tests on register 24. Extended branches double the sign-extended raw immediate.
- R7: Major 9 adds with rd=rs=rx and a sign-extended 8-bit immediate. Major 13 is an add with rd=rx, rs=0 and a zero-extended 8-bit immediate. Major 10 is set-less-than into register 24 with rs=rx. Major 14 is an XOR into register 24 with rs=rx. Both use a zero-extended 8-bit immediate. When extended, majors 13 and 14 zero-extend the 16-bit raw immediate and the others sign-extend it.
- R8: Major 28 with function bits 1:0 equal to 1 adds and equal to 3 subtracts, with rd=rz, rs=rx, rt=ry. Major 29 with bits 4:0 equal to 2 (set-less-than) or 10 (XOR) writes register 24. Values 12, 13 and 14 (AND, OR, XOR) write rd=rx. All use rs=rx, rt=ry. These operations clear `out_imm_sel`; every other valid operation sets it.
- R9: Major 3 is the 32-bit jump: length 4, rd=31, immediate {bits 4:0, bits 9:5, `in_window[31:16]`} shifted left by 2. Bit 10 set selects the mode-switching variant.
- R10: Unlisted majors, unlisted function codes, extended forms of majors 28 and 29, and a prefix followed by a prefix or by the jump all set `out_rsvd`. The op is then reserved and the registers, immediate and immediate select are zero. `out_len4` still reports whether a prefix was consumed.
- R11: `out_op` encodes the operation as its position in the list ADD, SUB, SLT, XOR, AND, OR, SLL, SRL, SRA, LB, LH, LW, SB, SH, SW, B, BEQZ, BNEZ, JAL, JALX, ILL (0 to 20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window holds an instruction to decode |
| in_window | input | 32 | First halfword in bits 15:0, next halfword in bits 31:16 |
| out_valid | output | 1 | Micro-op register holds a decode |
| out_op | output | 5 | Operation code (R11) |
| out_rd | output | 5 | Destination register |
| out_rs | output | 5 | First source register |
| out_rt | output | 5 | Second source register |
| out_imm | output | 32 | Extended and scaled immediate |
| out_imm_sel | output | 1 | Immediate is an operand |
| out_len4 | output | 1 | Instruction occupies four bytes |
| out_rsvd | output | 1 | Reserved-instruction flag |

## Verification
On every cycle the assertions hold several properties. The valid pipeline and the length a prefix forces must be right one cycle later. A reserved decode must not name a register or carry an immediate. Any destination must fall in the mapped register subset, the test register or the link register. A jump must always be four bytes long and link to register 31, and an unextended load offset must be aligned to its access size. Only the bench's scenarios can show the exact field values: immediate bit assembly, sign versus zero extension, scaling, the shift amount of zero meaning eight, and the choice of register 24. They also cover the specific reserved combinations, such as a prefix in front of a prefix or in front of the jump.

// File: rtl/c16_pkg.sv
package c16_pkg;

    localparam int HW    = 16;
    localparam int XLEN  = 32;
    localparam int RW    = 5;
    localparam int FW    = 3;
    localparam int NFLD  = 3;

    localparam logic [4:0] MJ_B     = 5'd2;
    localparam logic [4:0] MJ_JAL   = 5'd3;
    localparam logic [4:0] MJ_BEQZ  = 5'd4;
    localparam logic [4:0] MJ_BNEZ  = 5'd5;
    localparam logic [4:0] MJ_SHIFT = 5'd6;
    localparam logic [4:0] MJ_ADDI  = 5'd9;
    localparam logic [4:0] MJ_SLTI  = 5'd10;
    localparam logic [4:0] MJ_TBR   = 5'd12;
    localparam logic [4:0] MJ_LI    = 5'd13;
    localparam logic [4:0] MJ_CMPI  = 5'd14;
    localparam logic [4:0] MJ_LB    = 5'd16;
    localparam logic [4:0] MJ_LH    = 5'd17;
    localparam logic [4:0] MJ_LW    = 5'd19;
    localparam logic [4:0] MJ_SB    = 5'd24;
    localparam logic [4:0] MJ_SH    = 5'd25;
    localparam logic [4:0] MJ_SW    = 5'd27;
    localparam logic [4:0] MJ_RRR   = 5'd28;
    localparam logic [4:0] MJ_RR    = 5'd29;
    localparam logic [4:0] MJ_PFX   = 5'd30;

    localparam logic [RW-1:0] REG_T    = 5'd24;
    localparam logic [RW-1:0] REG_LINK = 5'd31;

    typedef enum logic [4:0] {
        UOP_ADD, UOP_SUB, UOP_SLT, UOP_XOR, UOP_AND, UOP_OR,
        UOP_SLL, UOP_SRL, UOP_SRA,
        UOP_LB, UOP_LH, UOP_LW, UOP_SB, UOP_SH, UOP_SW,
        UOP_B, UOP_BEQZ, UOP_BNEZ, UOP_JAL, UOP_JALX, UOP_ILL
    } uop_e;

    typedef struct packed {
        uop_e            op;
        logic [RW-1:0]   rd;
        logic [RW-1:0]   rs;
        logic [RW-1:0]   rt;
        logic [XLEN-1:0] imm;
        logic            imm_sel;
        logic            len4;
        logic            rsvd;
    } uop_t;

    typedef struct packed {
        logic          ext;
        logic [4:0]    major;
        logic [RW-1:0] rx;
        logic [RW-1:0] ry;
        logic [RW-1:0] rz;
        logic [HW-1:0] ins;
        logic [HW-1:0] nxt;
        logic [4:0]    pfx_hi;
        logic [5:0]    pfx_mid;
    } fields_t;

    typedef struct packed {
        logic [XLEN-1:0] ext_s;
        logic [XLEN-1:0] ext_z;
        logic [XLEN-1:0] ext_br;
        logic [XLEN-1:0] s8;
        logic [XLEN-1:0] z8;
        logic [XLEN-1:0] br8;
        logic [XLEN-1:0] br11;
        logic [XLEN-1:0] off5;
        logic [XLEN-1:0] sha;
        logic [XLEN-1:0] shx;
        logic [XLEN-1:0] jidx;
    } imm_cand_t;

    function automatic logic [RW-1:0] map_reg(input logic [FW-1:0] code);
        case (code)
            3'd0:    return 5'd16;
            3'd1:    return 5'd17;
            default: return {{(RW-FW){1'b0}}, code};
        endcase
    endfunction

endpackage

// File: rtl/c16_split.sv
module c16_split
    import c16_pkg::*;
(
    input  logic [2*HW-1:0] window,
    output fields_t         f
);
    logic          is_pfx;
    logic [HW-1:0] ins;
    logic [FW-1:0] code   [NFLD];
    logic [RW-1:0] mapped [NFLD];

    assign is_pfx  = (window[HW-1:HW-5] == MJ_PFX);
    assign ins     = is_pfx ? window[2*HW-1:HW] : window[HW-1:0];
    assign code[0] = ins[10:8];
    assign code[1] = ins[7:5];
    assign code[2] = ins[4:2];

    for (genvar k = 0; k < NFLD; k++) begin : g_map
        assign mapped[k] = map_reg(code[k]);
    end

    always_comb begin
        f         = '0;
        f.ext     = is_pfx;
        f.major   = ins[15:11];
        f.rx      = mapped[0];
        f.ry      = mapped[1];
        f.rz      = mapped[2];
        f.ins     = ins;
        f.nxt     = window[2*HW-1:HW];
        f.pfx_hi  = is_pfx ? window[4:0]  : 5'd0;
        f.pfx_mid = is_pfx ? window[10:5] : 6'd0;
    end
endmodule

// File: rtl/c16_imm.sv
module c16_imm
    import c16_pkg::*;
(
    input  fields_t   f,
    output imm_cand_t c
);
    logic [HW-1:0] raw;
    logic          unused_imm_bits;

    assign raw = {f.pfx_hi, f.pfx_mid, f.ins[4:0]};
    assign unused_imm_bits = ^{f.ext, f.major, f.rx, f.ry, f.rz, f.ins[15:11]};

    always_comb begin
        c        = '0;
        c.ext_s  = {{(XLEN-HW){raw[HW-1]}}, raw};
        c.ext_z  = {{(XLEN-HW){1'b0}}, raw};
        c.ext_br = {{(XLEN-HW-1){raw[HW-1]}}, raw, 1'b0};
        c.s8     = {{(XLEN-8){f.ins[7]}}, f.ins[7:0]};
        c.z8     = {{(XLEN-8){1'b0}}, f.ins[7:0]};
        c.br8    = {{(XLEN-9){f.ins[7]}}, f.ins[7:0], 1'b0};
        c.br11   = {{(XLEN-12){f.ins[10]}}, f.ins[10:0], 1'b0};
        c.off5   = {{(XLEN-5){1'b0}}, f.ins[4:0]};
        c.sha    = (f.ins[4:2] == 3'd0) ? XLEN'(8) : {{(XLEN-3){1'b0}}, f.ins[4:2]};
        c.shx    = {{(XLEN-5){1'b0}}, f.pfx_mid[5:1]};
        c.jidx   = {{(XLEN-28){1'b0}}, f.ins[4:0], f.ins[9:5], f.nxt, 2'b00};
    end
endmodule

// File: rtl/c16_op_decode.sv
module c16_op_decode
    import c16_pkg::*;
(
    input  fields_t   f,
    input  imm_cand_t c,
    output uop_t      u
);
    logic bad;
    logic unused_dec_bits;

    assign unused_dec_bits = ^{f.ins[15:11], f.ins[7:5], f.nxt, f.pfx_hi, f.pfx_mid};

    always_comb begin
        u         = '0;
        u.op      = UOP_ILL;
        u.len4    = f.ext;
        u.imm_sel = 1'b1;
        bad       = 1'b0;
        case (f.major)
            MJ_B: begin
                u.op  = UOP_B;
                u.imm = f.ext ? c.ext_br : c.br11;
            end
            MJ_BEQZ, MJ_BNEZ: begin
                u.op  = (f.major == MJ_BEQZ) ? UOP_BEQZ : UOP_BNEZ;
                u.rs  = f.rx;
                u.imm = f.ext ? c.ext_br : c.br8;
            end
            MJ_TBR: begin
                u.rs  = REG_T;
                u.imm = f.ext ? c.ext_br : c.br8;
                case (f.ins[10:8])
                    3'd0:    u.op = UOP_BEQZ;
                    3'd1:    u.op = UOP_BNEZ;
                    default: bad  = 1'b1;
                endcase
            end
            MJ_JAL: begin
                bad    = f.ext;
                u.op   = f.ins[10] ? UOP_JALX : UOP_JAL;
                u.rd   = REG_LINK;
                u.imm  = c.jidx;
                u.len4 = 1'b1;
            end
            MJ_SHIFT: begin
                u.rd  = f.rx;
                u.rs  = f.ry;
                u.imm = f.ext ? c.shx : c.sha;
                case (f.ins[1:0])
                    2'd0:    u.op = UOP_SLL;
                    2'd2:    u.op = UOP_SRL;
                    2'd3:    u.op = UOP_SRA;
                    default: bad  = 1'b1;
                endcase
            end
            MJ_ADDI: begin
                u.op  = UOP_ADD;
                u.rd  = f.rx;
                u.rs  = f.rx;
                u.imm = f.ext ? c.ext_s : c.s8;
            end
            MJ_LI: begin
                u.op  = UOP_ADD;
                u.rd  = f.rx;
                u.imm = f.ext ? c.ext_z : c.z8;
            end
            MJ_SLTI: begin
                u.op  = UOP_SLT;
                u.rd  = REG_T;
                u.rs  = f.rx;
                u.imm = f.ext ? c.ext_s : c.z8;
            end
            MJ_CMPI: begin
                u.op  = UOP_XOR;
                u.rd  = REG_T;
                u.rs  = f.rx;
                u.imm = f.ext ? c.ext_z : c.z8;
            end
            MJ_LB, MJ_LH, MJ_LW: begin
                u.rd = f.ry;
                u.rs = f.rx;
                if (f.major == MJ_LB) begin
                    u.op = UOP_LB; u.imm = f.ext ? c.ext_s : c.off5;
                end else if (f.major == MJ_LH) begin
                    u.op = UOP_LH; u.imm = f.ext ? c.ext_s : (c.off5 << 1);
                end else begin
                    u.op = UOP_LW; u.imm = f.ext ? c.ext_s : (c.off5 << 2);
                end
            end
            MJ_SB, MJ_SH, MJ_SW: begin
                u.rs = f.rx;
                u.rt = f.ry;
                if (f.major == MJ_SB) begin
                    u.op = UOP_SB; u.imm = f.ext ? c.ext_s : c.off5;
                end else if (f.major == MJ_SH) begin
                    u.op = UOP_SH; u.imm = f.ext ? c.ext_s : (c.off5 << 1);
                end else begin
                    u.op = UOP_SW; u.imm = f.ext ? c.ext_s : (c.off5 << 2);
                end
            end
            MJ_RRR: begin
                bad       = f.ext;
                u.imm_sel = 1'b0;
                u.rd      = f.rz;
                u.rs      = f.rx;
                u.rt      = f.ry;
                case (f.ins[1:0])
                    2'd1:    u.op = UOP_ADD;
                    2'd3:    u.op = UOP_SUB;
                    default: bad  = 1'b1;
                endcase
            end
            MJ_RR: begin
                bad       = f.ext;
                u.imm_sel = 1'b0;
                u.rs      = f.rx;
                u.rt      = f.ry;
                u.rd      = f.rx;
                case (f.ins[4:0])
                    5'd2:    begin u.op = UOP_SLT; u.rd = REG_T; end
                    5'd10:   begin u.op = UOP_XOR; u.rd = REG_T; end
                    5'd12:   u.op = UOP_AND;
                    5'd13:   u.op = UOP_OR;
                    5'd14:   u.op = UOP_XOR;
                    default: bad  = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase
        if (bad) begin
            u      = '0;
            u.op   = UOP_ILL;
            u.rsvd = 1'b1;
            u.len4 = f.ext;
        end
    end
endmodule

// File: rtl/c16_decoder.sv
module c16_decoder
    import c16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     in_window,
    output logic            out_valid,
    output logic [4:0]      out_op,
    output logic [4:0]      out_rd,
    output logic [4:0]      out_rs,
    output logic [4:0]      out_rt,
    output logic [31:0]     out_imm,
    output logic            out_imm_sel,
    output logic            out_len4,
    output logic            out_rsvd
);
    fields_t   fld;
    imm_cand_t cand;
    uop_t      nxt_uop;
    uop_t      q;
    logic      q_valid;

    c16_split     split_i  (.window(in_window), .f(fld));
    c16_imm       imm_i    (.f(fld), .c(cand));
    c16_op_decode decode_i (.f(fld), .c(cand), .u(nxt_uop));

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q       <= nxt_uop;
            q_valid <= in_valid;
        end
    end

    assign out_valid   = q_valid;
    assign out_op      = q.op;
    assign out_rd      = q.rd;
    assign out_rs      = q.rs;
    assign out_rt      = q.rt;
    assign out_imm     = q.imm;
    assign out_imm_sel = q.imm_sel;
    assign out_len4    = q.len4;
    assign out_rsvd    = q.rsvd;
endmodule

// File: rtl/c16_decoder_chk.sv
module c16_decoder_chk
    import c16_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_window,
    input logic        out_valid,
    input logic [4:0]  out_op,
    input logic [4:0]  out_rd,
    input logic [31:0] out_imm,
    input logic        out_imm_sel,
    input logic        out_len4,
    input logic        out_rsvd
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    prefix_len_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_window[15:11] == MJ_PFX) |=> out_len4);
    // R10
    rsvd_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_rsvd) |-> (out_op == UOP_ILL && out_rd == 5'd0
                                     && out_imm == 32'd0 && !out_imm_sel));
    // R2
    rd_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_rsvd && out_rd != 5'd0)
            |-> (out_rd inside {5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
                                5'd16, 5'd17, 5'd24, 5'd31}));
    // R9
    jump_form_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_op == UOP_JAL || out_op == UOP_JALX))
            |-> (out_len4 && out_rd == REG_LINK));
    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_len4 && out_op == UOP_LW)
            |-> (out_imm[1:0] == 2'b00 && out_imm < 32'd128));
    // R5
    half_align_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_len4 && out_op == UOP_LH)
            |-> (out_imm[0] == 1'b0 && out_imm < 32'd64));
endmodule

bind c16_decoder c16_decoder_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_window(in_window),
    .out_valid(out_valid), .out_op(out_op), .out_rd(out_rd),
    .out_imm(out_imm), .out_imm_sel(out_imm_sel), .out_len4(out_len4),
    .out_rsvd(out_rsvd)
);

// File: tb/c16_decoder_tb_top.sv
`timescale 1ns/1ps
module c16_decoder_tb_top;
    import c16_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_window = '0;
    logic        out_valid;
    logic [4:0]  out_op, out_rd, out_rs, out_rt;
    logic [31:0] out_imm;
    logic        out_imm_sel, out_len4, out_rsvd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    c16_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_window(in_window),
        .out_valid(out_valid), .out_op(out_op), .out_rd(out_rd),
        .out_rs(out_rs), .out_rt(out_rt), .out_imm(out_imm),
        .out_imm_sel(out_imm_sel), .out_len4(out_len4), .out_rsvd(out_rsvd)
    );

    typedef struct {
        int          op;
        int          rd;
        int          rs;
        int          rt;
        logic [31:0] imm;
        bit          isel;
        bit          l4;
        bit          rsv;
    } exp_t;

    function automatic int rmap(logic [2:0] c);
        int tbl [8] = '{16, 17, 2, 3, 4, 5, 6, 7};
        return tbl[c];
    endfunction

    // behavioural reference of R2..R11
    function automatic exp_t model(logic [31:0] w);
        exp_t e;
        bit x, bad;
        logic [15:0] p, i;
        int mj, a, b, z, s16, u16, fn;
        x = (w[15:11] == 5'd30);
        p = x ? w[15:0] : 16'h0;
        i = x ? w[31:16] : w[15:0];
        mj = int'(i[15:11]);
        a = rmap(i[10:8]); b = rmap(i[7:5]); z = rmap(i[4:2]);
        u16 = int'({p[4:0], p[10:5], i[4:0]});
        s16 = (u16 >= 32768) ? u16 - 65536 : u16;
        e.op = int'(UOP_ILL); e.rd = 0; e.rs = 0; e.rt = 0; e.imm = 0;
        e.isel = 1; e.l4 = x; e.rsv = 0; bad = 0;
        if (mj == 2) begin
            e.op = int'(UOP_B);
            e.imm = x ? 32'(s16 * 2) : 32'(($signed(i[10:0]) + 0) * 2);
        end else if (mj == 4 || mj == 5 || mj == 12) begin
            e.op = (mj == 4) ? int'(UOP_BEQZ) : int'(UOP_BNEZ);
            e.rs = a;
            if (mj == 12) begin
                e.rs = 24;
                fn = int'(i[10:8]);
                if (fn == 0) e.op = int'(UOP_BEQZ);
                else if (fn == 1) e.op = int'(UOP_BNEZ);
                else bad = 1;
            end
            e.imm = x ? 32'(s16 * 2) : 32'(($signed(i[7:0]) + 0) * 2);
        end else if (mj == 3) begin
            if (x) bad = 1;
            e.op = i[10] ? int'(UOP_JALX) : int'(UOP_JAL);
            e.rd = 31; e.l4 = 1;
            e.imm = 32'((int'(i[4:0]) * 2097152 + int'(i[9:5]) * 65536 + int'(w[31:16])) * 4);
        end else if (mj == 6) begin
            e.rd = a; e.rs = b;
            fn = int'(i[1:0]);
            if (fn == 0) e.op = int'(UOP_SLL);
            else if (fn == 2) e.op = int'(UOP_SRL);
            else if (fn == 3) e.op = int'(UOP_SRA);
            else bad = 1;
            if (x) e.imm = 32'(int'(p[10:6]));
            else e.imm = (i[4:2] == 3'd0) ? 32'd8 : 32'(int'(i[4:2]));
        end else if (mj == 9) begin
            e.op = int'(UOP_ADD); e.rd = a; e.rs = a;
            e.imm = x ? 32'(s16) : 32'($signed(i[7:0]) + 0);
        end else if (mj == 13) begin
            e.op = int'(UOP_ADD); e.rd = a;
            e.imm = x ? 32'(u16) : 32'(int'(i[7:0]));
        end else if (mj == 10) begin
            e.op = int'(UOP_SLT); e.rd = 24; e.rs = a;
            e.imm = x ? 32'(s16) : 32'(int'(i[7:0]));
        end else if (mj == 14) begin
            e.op = int'(UOP_XOR); e.rd = 24; e.rs = a;
            e.imm = x ? 32'(u16) : 32'(int'(i[7:0]));
        end else if (mj == 16 || mj == 17 || mj == 19 || mj == 24 || mj == 25 || mj == 27) begin
            int sz;
            sz = (mj == 16 || mj == 24) ? 1 : ((mj == 17 || mj == 25) ? 2 : 4);
            if (mj < 20) begin
                e.rd = b; e.rs = a;
                e.op = (sz == 1) ? int'(UOP_LB) : ((sz == 2) ? int'(UOP_LH) : int'(UOP_LW));
            end else begin
                e.rs = a; e.rt = b;
                e.op = (sz == 1) ? int'(UOP_SB) : ((sz == 2) ? int'(UOP_SH) : int'(UOP_SW));
            end
            e.imm = x ? 32'(s16) : 32'(int'(i[4:0]) * sz);
        end else if (mj == 28) begin
            e.isel = 0; e.rd = z; e.rs = a; e.rt = b;
            if (x) bad = 1;
            if (i[1:0] == 2'd1) e.op = int'(UOP_ADD);
            else if (i[1:0] == 2'd3) e.op = int'(UOP_SUB);
            else bad = 1;
        end else if (mj == 29) begin
            e.isel = 0; e.rs = a; e.rt = b; e.rd = a;
            if (x) bad = 1;
            fn = int'(i[4:0]);
            if (fn == 2) begin e.op = int'(UOP_SLT); e.rd = 24; end
            else if (fn == 10) begin e.op = int'(UOP_XOR); e.rd = 24; end
            else if (fn == 12) e.op = int'(UOP_AND);
            else if (fn == 13) e.op = int'(UOP_OR);
            else if (fn == 14) e.op = int'(UOP_XOR);
            else bad = 1;
        end else begin
            bad = 1;
        end
        if (bad) begin
            e.op = int'(UOP_ILL); e.rd = 0; e.rs = 0; e.rt = 0; e.imm = 0;
            e.isel = 0; e.l4 = x; e.rsv = 1;
        end
        return e;
    endfunction

    function automatic logic [15:0] ins(int mj, int x, int y, int lo);
        return {5'(mj), 3'(x), 3'(y), 5'(lo)};
    endfunction
    function automatic logic [15:0] ins8(int mj, int x, int v);
        return {5'(mj), 3'(x), 8'(v)};
    endfunction
    function automatic logic [15:0] pfx(logic [15:0] v);
        return {5'd30, v[10:5], v[15:11]};
    endfunction

    task automatic compare(string req, exp_t e);
        checks++;
        if (out_valid !== 1'b1 || int'(out_op) != e.op || int'(out_rd) != e.rd ||
            int'(out_rs) != e.rs || int'(out_rt) != e.rt || out_imm !== e.imm ||
            out_imm_sel !== e.isel || out_len4 !== e.l4 || out_rsvd !== e.rsv) begin
            errors++;
            $display("FAIL %s: got v=%0b op=%0d rd=%0d rs=%0d rt=%0d imm=%h sel=%0b l4=%0b rsv=%0b exp v=1 op=%0d rd=%0d rs=%0d rt=%0d imm=%h sel=%0b l4=%0b rsv=%0b",
                     req, out_valid, out_op, out_rd, out_rs, out_rt, out_imm, out_imm_sel,
                     out_len4, out_rsvd, e.op, e.rd, e.rs, e.rt, e.imm, e.isel, e.l4, e.rsv);
        end
    endtask

    task automatic send(logic [31:0] w, string req);
        exp_t e;
        in_window = w;
        in_valid  = 1'b1;
        e = model(w);
        @(negedge clk);
        compare(req, e);
    endtask

    task automatic idle(string req);
        in_valid  = 1'b0;
        in_window = 32'hFFFF_FFFF;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: out_valid got %0b exp 0", req, out_valid);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || out_op !== 5'd0 || out_rd !== 5'd0 || out_rs !== 5'd0 ||
            out_rt !== 5'd0 || out_imm !== 32'd0 || out_imm_sel !== 1'b0 ||
            out_len4 !== 1'b0 || out_rsvd !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset fields got v=%0b op=%0d imm=%h exp all zero",
                     out_valid, out_op, out_imm);
        end
        rst = 1'b0;
        idle("R1");

        // R2: every register code, through the immediate load
        for (int k = 0; k < 8; k++) send({16'h0, ins8(13, k, 8'h5A)}, "R2");
        // R7 immediate forms
        send({16'h0, ins8(9, 0, 8'hFB)}, "R7");
        send({16'h0, ins8(13, 1, 8'hF0)}, "R7");
        send({16'h0, ins8(10, 7, 8'h80)}, "R7");
        send({16'h0, ins8(14, 4, 8'hC3)}, "R7");
        // R3 prefixed immediates: zero- and sign-extension
        send({ins8(14, 3, 8'h01), pfx(16'h8001)}, "R3");
        send({ins8(9, 2, 8'h10), pfx(16'hFFF0)}, "R3");
        send({ins8(10, 5, 8'h1F), pfx(16'h9ABF)}, "R3");
        // R4 shifts
        send({16'h0, ins(6, 2, 5, 0)}, "R4");
        send({16'h0, ins(6, 4, 3, (5 << 2) | 3)}, "R4");
        send({ins(6, 0, 1, 2), pfx(16'h0000)}, "R4");
        send({ins(6, 6, 7, 0), pfx(16'd31 << 6)}, "R4");
        // R5 loads and stores
        send({16'h0, ins(19, 0, 1, 31)}, "R5");
        send({16'h0, ins(17, 3, 4, 3)}, "R5");
        send({16'h0, ins(24, 5, 6, 7)}, "R5");
        send({16'h0, ins(25, 7, 0, 31)}, "R5");
        send({ins(27, 2, 3, 4), pfx(16'h8004)}, "R5");
        send({ins(16, 1, 1, 31), pfx(16'h07FF)}, "R5");
        // R6 branches
        send({16'h0, 5'd2, 11'h401}, "R6");
        send({16'h0, ins8(5, 6, 8'h7F)}, "R6");
        send({16'h0, ins8(12, 0, 8'hFE)}, "R6");
        send({16'h0, ins8(12, 1, 8'h02)}, "R6");
        send({ins8(4, 1, 8'h14), pfx(16'h1234)}, "R6");
        send({ins(2, 0, 0, 1), pfx(16'hFFC0)}, "R6");
        // R9 jumps
        send({16'hBEEF, 5'd3, 1'b0, 5'h0A, 5'h15}, "R9");
        send({16'h0001, 5'd3, 1'b1, 5'h1F, 5'h1F}, "R9");
        // R8 register operations
        send({16'h0, ins(28, 5, 6, (7 << 2) | 3)}, "R8");
        send({16'h0, ins(28, 0, 1, (2 << 2) | 1)}, "R8");
        send({16'h0, ins(29, 0, 1, 12)}, "R8");
        send({16'h0, ins(29, 2, 3, 2)}, "R8");
        send({16'h0, ins(29, 4, 5, 10)}, "R8");
        send({16'h0, ins(29, 6, 7, 13)}, "R8");
        idle("R1");
        // R10 reserved combinations
        send({16'h0, ins(6, 1, 2, 1)}, "R10");
        send({16'h0, ins8(12, 5, 8'h10)}, "R10");
        send({16'h0, ins(28, 1, 2, 0)}, "R10");
        send({16'h0, ins(29, 1, 2, 0)}, "R10");
        send({16'h0, ins(0, 1, 2, 3)}, "R10");
        send({16'h0, ins(31, 7, 7, 31)}, "R10");
        send({pfx(16'h1111), pfx(16'h2222)}, "R10");
        send({ins(3, 0, 0, 0), pfx(16'h0)}, "R10");
        send({ins(29, 0, 1, 12), pfx(16'h0)}, "R10");
        // R11 op numbering checked on a fixed value
        send({16'h0, ins(6, 0, 0, 3)}, "R11");
        checks++;
        if (out_op !== 5'd8) begin
            errors++;
            $display("FAIL R11: arithmetic-right op got %0d exp 8", out_op);
        end
        idle("R1");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule